// File: doc/BRIEF.md
# Time-Slice Readout Word Formatter

This block turns the per-slice activity of a 64-channel front-end into a serial stream of 11-bit words, one word for each time slice (one clock). It keeps a 24-bit timestamp that advances once per slice and returns to zero after a configurable count, which is one second at a 10 MHz slice rate by default.

While nothing is waiting to be sent, the stream alternates between a fixed sync word and a status word. The status word reports four mode bits and the low three timestamp bits. When an event is accepted, the next sync slot opens a frame. The frame holds the event's timestamp in three time words, followed by its 64-bit hit pattern in eight data words. Sync and status alternation then resumes. A frame takes exactly 12 slices, counting the sync word that opens it. Each non-sync word carries one byte in bits 10:3 and a 3-bit type tag in bits 2:0. No tag value allows a status, time or data word to match the sync pattern.

An event that arrives while a frame is being sent waits in a one-deep holding slot. An event that finds the slot occupied is discarded and raises a sticky overflow flag.

Top module: `slice_frame_fmt`

## Requirements
- R1: While rst_ni is low, word_vld_o and overflow_o are 0. After reset is released, word_vld_o is 1 from the first clock edge onward, and the first valid word is the sync word.
- R2: Word encodings are as follows. The sync word is 11'h001. A status word is {byte, 3'b111}, a time word is {byte, 3'b101} and a data word is {byte, 3'b011}, with the byte in bits 10:3.
- R3: With no event waiting, a sync word is followed by a status word, and a status word is followed by a sync word.
- R4: The status byte, from bit 10 down to bit 3, is acc_all_i, trig_mode_i, sync_en_i, pipe_en_i, then a constant 0, then timestamp bits 2..0 of the current slice.
- R5: The timestamp is 0 in the slice after reset release and rises by one per slice. After TS_WRAP-1 it returns to 0.
- R6: Once an event is accepted, a later sync slot starts a frame of the sync word plus 11 words. The frame is followed by a sync word, which is then followed by a status word if nothing else is waiting.
- R7: The three time words carry bits 7:0, then 15:8, then 23:16 of the timestamp of the slice in which hit_vld_i was high.
- R8: The eight data words carry hit_i bits 7:0 first and bits 63:56 last, in ascending byte order.
- R9: Frame contents are fixed when the event is accepted. Later changes of hit_i and later timestamp increments do not alter them.
- R10: An event accepted while a frame is in progress is held. It is sent as the next frame, directly after the sync word that ends the current frame, and overflow_o stays 0.
- R11: An event that arrives while the holding slot is full and no frame is being loaded from it is dropped and never sent. overflow_o then goes to 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slice clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_vld_i | input | 1 | Event strobe for this slice |
| hit_i | input | 64 | Hit pattern of the event |
| acc_all_i | input | 1 | Accept-all-hits mode bit, reported in status |
| trig_mode_i | input | 1 | Triggered (1) or data-push (0) mode bit, reported in status |
| sync_en_i | input | 1 | Sync-pulse enable mode bit, reported in status |
| pipe_en_i | input | 1 | Pipeline enable mode bit, reported in status |
| word_o | output | 11 | Output word of the current slice |
| word_vld_o | output | 1 | word_o is valid |
| overflow_o | output | 1 | Sticky flag, set when an event is dropped |

## Verification
The bench builds the block with TS_WRAP set to 70001 and leaves the other parameters at their defaults. With that value the timestamp wraps after about 70 thousand slices, so a frame that straddles the wrap and status words after it both fall inside a short run. The timestamp values just below the wrap also have nonzero bits in all three time bytes. Because 70001 is not a multiple of 8, a counter that failed to wrap would show the wrong low bits in the status word.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam int unsigned WORD_W = 11;
  localparam logic [2:0]  TAG_STAT  = 3'b111;
  localparam logic [2:0]  TAG_TIME  = 3'b101;
  localparam logic [2:0]  TAG_DATA  = 3'b011;
  localparam logic [WORD_W-1:0] SYNC_WORD = 11'b000_0000_0001;

  typedef enum logic [1:0] {
    SLOT_SYNC  = 2'd0,
    SLOT_STAT  = 2'd1,
    SLOT_FRAME = 2'd2
  } slot_e;

  typedef struct packed {
    logic acc_all;
    logic trig;
    logic sync_en;
    logic pipe_en;
  } mode_t;
endpackage

// File: rtl/sff_ts_cnt.sv
module sff_ts_cnt #(
  parameter int unsigned TS_W    = 24,
  parameter int unsigned TS_WRAP = 10_000_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] ts_o
);
  localparam logic [TS_W-1:0] TS_LAST = TS_W'(TS_WRAP - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ts_o <= '0;
    else if (ts_o == TS_LAST) ts_o <= '0;
    else                      ts_o <= ts_o + TS_W'(1);
  end
endmodule

// File: rtl/sff_evt_buf.sv
// One-deep event holding slot; a take and a new event in the same slice refill it.
module sff_evt_buf #(
  parameter int unsigned HIT_W = 64,
  parameter int unsigned TS_W  = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_vld_i,
  input  logic [HIT_W-1:0] evt_hits_i,
  input  logic [TS_W-1:0]  evt_ts_i,
  input  logic             take_i,
  output logic             pend_o,
  output logic [HIT_W-1:0] hits_o,
  output logic [TS_W-1:0]  ts_o,
  output logic             ovf_o
);
  logic load;
  assign load = evt_vld_i && (take_i || !pend_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      hits_o <= '0;
      ts_o   <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (load) begin
        pend_o <= 1'b1;
        hits_o <= evt_hits_i;
        ts_o   <= evt_ts_i;
      end else if (take_i) begin
        pend_o <= 1'b0;
      end
      if (evt_vld_i && !load) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sff_seq.sv
module sff_seq #(
  parameter int unsigned FRAME_LEN = 11,
  localparam int unsigned IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pend_i,
  output logic                 take_o,
  output sff_pkg::slot_e       slot_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 vld_o
);
  import sff_pkg::*;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);

  assign take_o = vld_o && (slot_o == SLOT_SYNC) && pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      slot_o <= SLOT_SYNC;
      idx_o  <= '0;
    end else begin
      vld_o <= 1'b1;
      if (vld_o) begin
        unique case (slot_o)
          SLOT_SYNC: begin
            idx_o  <= '0;
            slot_o <= pend_i ? SLOT_FRAME : SLOT_STAT;
          end
          SLOT_STAT: slot_o <= SLOT_SYNC;
          SLOT_FRAME: begin
            if (idx_o == IDX_LAST) begin
              slot_o <= SLOT_SYNC;
              idx_o  <= '0;
            end else begin
              idx_o <= idx_o + IDX_W'(1);
            end
          end
          default: slot_o <= SLOT_SYNC;
        endcase
      end
    end
  end
endmodule

// File: rtl/sff_word_gen.sv
module sff_word_gen #(
  parameter int unsigned HIT_W = 64,
  parameter int unsigned TS_W  = 24,
  localparam int unsigned N_TS_B    = TS_W / 8,
  localparam int unsigned N_HIT_B   = HIT_W / 8,
  localparam int unsigned FRAME_LEN = N_TS_B + N_HIT_B,
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [HIT_W-1:0]              hits_i,
  input  logic [TS_W-1:0]               ts_i,
  input  sff_pkg::slot_e                slot_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  sff_pkg::mode_t                mode_i,
  input  logic [2:0]                    ts_low_i,
  output logic [sff_pkg::WORD_W-1:0]    word_o
);
  import sff_pkg::*;

  logic [HIT_W-1:0]  frm_hits;
  logic [TS_W-1:0]   frm_ts;
  logic [WORD_W-1:0] frame_words [FRAME_LEN];
  logic [WORD_W-1:0] stat_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_hits <= '0;
      frm_ts   <= '0;
    end else if (load_i) begin
      frm_hits <= hits_i;
      frm_ts   <= ts_i;
    end
  end

  for (genvar g = 0; g < N_TS_B; g++) begin : g_time
    assign frame_words[g] = {frm_ts[8*g +: 8], TAG_TIME};
  end
  for (genvar h = 0; h < N_HIT_B; h++) begin : g_data
    assign frame_words[N_TS_B + h] = {frm_hits[8*h +: 8], TAG_DATA};
  end

  assign stat_word = {mode_i.acc_all, mode_i.trig, mode_i.sync_en, mode_i.pipe_en,
                      1'b0, ts_low_i, TAG_STAT};

  always_comb begin
    word_o = SYNC_WORD;
    unique case (slot_i)
      SLOT_STAT:  word_o = stat_word;
      SLOT_FRAME: if (32'(idx_i) < FRAME_LEN) word_o = frame_words[idx_i];
      default:    word_o = SYNC_WORD;
    endcase
  end
endmodule

// File: rtl/slice_frame_fmt.sv
module slice_frame_fmt #(
  parameter int unsigned TS_W    = 24,
  parameter int unsigned TS_WRAP = 10_000_000,
  parameter int unsigned HIT_W   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_vld_i,
  input  logic [HIT_W-1:0] hit_i,
  input  logic             acc_all_i,
  input  logic             trig_mode_i,
  input  logic             sync_en_i,
  input  logic             pipe_en_i,
  output logic [10:0]      word_o,
  output logic             word_vld_o,
  output logic             overflow_o
);
  import sff_pkg::*;
  localparam int unsigned FRAME_LEN = TS_W / 8 + HIT_W / 8;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);

  logic [TS_W-1:0]  ts_q;
  logic             pend, take;
  logic [HIT_W-1:0] pend_hits;
  logic [TS_W-1:0]  pend_ts;
  slot_e            slot;
  logic [IDX_W-1:0] idx;
  mode_t            mode;

  assign mode = '{acc_all: acc_all_i, trig: trig_mode_i, sync_en: sync_en_i, pipe_en: pipe_en_i};

  sff_ts_cnt #(.TS_W(TS_W), .TS_WRAP(TS_WRAP)) i_ts (
    .clk_i, .rst_ni, .ts_o(ts_q)
  );

  sff_evt_buf #(.HIT_W(HIT_W), .TS_W(TS_W)) i_buf (
    .clk_i, .rst_ni,
    .evt_vld_i(hit_vld_i), .evt_hits_i(hit_i), .evt_ts_i(ts_q),
    .take_i(take), .pend_o(pend), .hits_o(pend_hits), .ts_o(pend_ts),
    .ovf_o(overflow_o)
  );

  sff_seq #(.FRAME_LEN(FRAME_LEN)) i_seq (
    .clk_i, .rst_ni, .pend_i(pend), .take_o(take),
    .slot_o(slot), .idx_o(idx), .vld_o(word_vld_o)
  );

  sff_word_gen #(.HIT_W(HIT_W), .TS_W(TS_W)) i_word (
    .clk_i, .rst_ni, .load_i(take), .hits_i(pend_hits), .ts_i(pend_ts),
    .slot_i(slot), .idx_i(idx), .mode_i(mode), .ts_low_i(ts_q[2:0]),
    .word_o(word_o)
  );
endmodule

// File: rtl/sff_chk.sv
module sff_chk #(
  parameter int unsigned FRAME_LEN = 11,
  parameter int unsigned TS_W      = 24,
  parameter int unsigned TS_WRAP   = 10_000_000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [10:0]     word_i,
  input logic            vld_i,
  input logic            ovf_i,
  input logic [TS_W-1:0] ts_i
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1) + 1;
  localparam logic [TS_W-1:0] TS_LAST = TS_W'(TS_WRAP - 1);

  logic [CNT_W-1:0] cnt;
  logic             seen_sync;
  logic             is_sync;

  assign is_sync = vld_i && (word_i == 11'h001);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt       <= '0;
      seen_sync <= 1'b0;
    end else if (vld_i) begin
      if (is_sync) begin
        cnt       <= '0;
        seen_sync <= 1'b1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  a_r1_vld_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_i);

  a_r3_sync_not_twice: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sync |=> (word_i != 11'h001));

  a_r3_status_then_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && word_i[2:0] == 3'b111) |=> (word_i == 11'h001));

  a_r6_frame_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sync && seen_sync) |-> (cnt == CNT_W'(1) || cnt == CNT_W'(FRAME_LEN)));

  a_r8_data_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && word_i[2:0] == 3'b011) |=> (word_i == 11'h001 || word_i[2:0] == 3'b011));

  a_r5_ts_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ts_i == (($past(ts_i) == TS_LAST) ? '0 : $past(ts_i) + TS_W'(1))));

  a_r4_status_ts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && word_i[2:0] == 3'b111) |-> (word_i[5:3] == ts_i[2:0] && !word_i[6]));

  a_r11_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i);
endmodule

bind slice_frame_fmt sff_chk #(
  .FRAME_LEN(FRAME_LEN), .TS_W(TS_W), .TS_WRAP(TS_WRAP)
) i_sff_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .word_i(word_o), .vld_i(word_vld_o),
  .ovf_i(overflow_o), .ts_i(ts_q)
);

// File: tb/test_slice_frame_fmt.sv
module test_slice_frame_fmt;
  localparam int W = 70001;
  localparam logic [10:0] SYNC = 11'h001;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hit_vld_i = 1'b0;
  logic [63:0] hit_i = '0;
  logic        acc_all_i = 1'b0, trig_mode_i = 1'b0, sync_en_i = 1'b0, pipe_en_i = 1'b0;
  logic [10:0] word_o;
  logic        word_vld_o, overflow_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  slice_frame_fmt #(.TS_WRAP(W)) i_slice_frame_fmt (.*);

  task automatic step(); @(negedge clk_i); endtask

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [10:0] f_stat();
    int t = cyc % W;
    logic [2:0] tl = t[2:0];
    return {acc_all_i, trig_mode_i, sync_en_i, pipe_en_i, 1'b0, tl, 3'b111};
  endfunction

  function automatic logic [10:0] f_frame(input int i, input logic [23:0] ts, input logic [63:0] h);
    if (i < 3) return {ts[8*i +: 8], 3'b101};
    return {h[8*(i-3) +: 8], 3'b011};
  endfunction

  task automatic align_sync();
    for (int n = 0; n < 16; n++) begin
      if (word_o == SYNC) break;
      step();
    end
  endtask

  // stops on the first time word of the next frame
  task automatic wait_body();
    logic [10:0] prev = word_o;
    for (int n = 0; n < 8; n++) begin
      step();
      if (prev == SYNC && word_o[2:0] == 3'b101) break;
      prev = word_o;
    end
  endtask

  task automatic chk_body(input string req, input int first, input logic [23:0] ts, input logic [63:0] h);
    for (int i = first; i < 11; i++) begin
      chk(i < 3 ? {req, " R7 time word"} : {req, " R8 data word"}, word_o, f_frame(i, ts, h));
      if (i < 10) step();
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) step();
    chk("R1 vld in reset", {10'd0, word_vld_o}, 11'd0);
    chk("R11 ovf in reset", {10'd0, overflow_o}, 11'd0);
    rst_ni = 1'b1;
    step();
    chk("R1 vld after reset", {10'd0, word_vld_o}, 11'd1);
    chk("R1 first word sync", word_o, SYNC);
    step();
    chk("R4 R5 first status ts", word_o, f_stat());
  endtask

  task automatic t_idle(input logic [3:0] m);
    {acc_all_i, trig_mode_i, sync_en_i, pipe_en_i} = m;
    align_sync();
    for (int k = 0; k < 4; k++) begin
      chk("R3 sync slot", word_o, SYNC);
      step();
      chk("R4 status word", word_o, f_stat());
      step();
    end
  endtask

  task automatic t_frame(input logic [63:0] h);
    logic [23:0] ts;
    align_sync();
    hit_vld_i = 1'b1; hit_i = h; ts = 24'(cyc % W);
    step();
    hit_vld_i = 1'b0; hit_i = ~h;  // R9 later input change
    wait_body();
    chk_body("R6 R9", 0, ts, h);
    step();
    chk("R6 closing sync", word_o, SYNC);
    step();
    chk("R6 status resumes", word_o, f_stat());
  endtask

  task automatic t_overflow();
    logic [23:0] ts_a, ts_b;
    logic [63:0] ha = 64'h0F1E_2D3C_4B5A_6978, hb = 64'h8796_A5B4_C3D2_E1F0, hc = 64'hDEAD_BEEF_0BAD_F00D;
    align_sync();
    hit_vld_i = 1'b1; hit_i = ha; ts_a = 24'(cyc % W);
    step();
    hit_vld_i = 1'b0;
    wait_body();
    chk("R7 A time0", word_o, f_frame(0, ts_a, ha));
    hit_vld_i = 1'b1; hit_i = hb; ts_b = 24'(cyc % W);
    step();
    chk("R10 no ovf on held event", {10'd0, overflow_o}, 11'd0);
    hit_i = hc;  // third event while slot full
    chk("R7 A time1", word_o, f_frame(1, ts_a, ha));
    step();
    hit_vld_i = 1'b0;
    chk_body("R10 A rest", 2, ts_a, ha);
    step();
    chk("R10 sync between frames", word_o, SYNC);
    step();
    chk_body("R10 held frame", 0, ts_b, hb);
    step();
    chk("R11 sync after held", word_o, SYNC);
    step();
    chk("R11 dropped event not sent", word_o, f_stat());
    chk("R11 overflow set", {10'd0, overflow_o}, 11'd1);
    repeat (5) step();
    chk("R11 overflow sticky", {10'd0, overflow_o}, 11'd1);
  endtask

  task automatic t_wrap();
    while (cyc < W - 4) step();
    t_frame(64'h0123_4567_89AB_CDEF);  // spans the wrap, R9
    t_idle(4'b1001);                   // R5 post-wrap status ts
    t_frame(64'h00FF_0001_8000_7F00);  // small ts after wrap, R5 R7
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_idle(4'b1010);
    t_idle(4'b0101);
    t_idle(4'b1111);
    t_frame(64'h8877_6655_4433_2211);
    t_frame(64'h0000_0000_0000_0000);  // R2 zero bytes never look like sync
    t_overflow();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule